// File: doc/BRIEF.md
# Shared-Channel Interrupt Source Router

This block collects a wide vector of device interrupt lines and folds them onto a small number of CPU interrupt channels. Every source owns an enable bit and a channel number, both held in registers. Any number of sources may point at the same channel. A channel raises its request when at least one enabled source assigned to it is active. For each channel the block also keeps the index of the winning source, which is the lowest-numbered active one. When nothing is pending, it keeps an all-ones "none" code instead.

A small bank of selectors picks individual sources for a single non-maskable interrupt line. This line is driven high when any selected source is high. A power-mode input holds every channel except a parameterised low group at zero, so that only that low group can wake a sleeping core. Software reaches the configuration, the selectors, the per-channel winner and a reverse lookup through one flat register port. The address has two space bits above a 10-bit index.

Top module: `irq_src_router`

## Requirements
- R1: After reset every source is disabled. All channel requests and the NMI output are 0. Every per-channel winner reads 10'h3FF, and every NMI selector holds 10'h3FF.
- R2: A write with address space 0 (address bits [11:10] = 0) and index i below NUM_SRC sets source i's enable from wdata bit 3 and its channel from wdata bits [2:0]. A read in space 0 returns {enable, channel} in bits [3:0], with the upper bits zero.
- R3: Channel request c goes high one clock after the inputs show an enabled source, assigned to c, that is high. A source input and a configuration that takes effect on the same edge both count. The request is the OR of all such sources.
- R4: A disabled source has no effect on any channel request or winner, whatever its input and channel field.
- R5: The winner of channel c, on act_idx_o[c*10 +: 10] and by a read in space 2 with index c, is the lowest-numbered enabled source assigned to c that is high. It is registered with the same one-clock latency as the request, and the power-mode input does not affect it.
- R6: A channel with no active assigned enabled source reports 10'h3FF as its winner.
- R7: Space 1, index k < NUM_NMI, holds NMI selector k, with a 10-bit source index written and read back in full. One clock after the inputs, nmi_o is the OR of the raw inputs of the selected sources, regardless of their enable bits. A selector holding 10'h3FF contributes nothing.
- R8: While deep_sleep_i is high, channel requests with index DS_CH or above are forced to 0 on the next clock. Channels below DS_CH behave as in R3.
- R9: A read in space 3 with index i returns the channel number of source i, zero-extended, if the source is enabled, and 10'h3FF if it is disabled.
- R10: A space-0 write with index NUM_SRC or above changes nothing. For such an index, a space-0 read returns 0 and a space-3 read returns 10'h3FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Device interrupt lines, active high |
| deep_sleep_i | input | 1 | Power-mode flag that masks the upper channels |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 12 | {space[1:0], index[9:0]} |
| cfg_wdata_i | input | 10 | Write data |
| cfg_rdata_o | output | 10 | Read data for cfg_addr_i, combinational |
| irq_o | output | NUM_CH | Per-channel CPU interrupt requests, registered |
| act_idx_o | output | NUM_CH*10 | Per-channel winning source index, registered |
| nmi_o | output | 1 | Non-maskable interrupt request, registered |

## Verification
Sources are driven one at a time to show the channel mapping. Two sources on one channel are driven together, lower and higher index first in turn, so that a priority search that picked the highest or the most recent index would be exposed. Disabled sources are driven alone to show they are invisible to the channels yet still reach an NMI selector. The power-mode input is toggled with sources on channels below and above the wake boundary. A long stretch of pseudo-random input words over a dense mixed configuration then compares every request, winner and NMI value against a software model cycle by cycle.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int IDX_W = 10;
  localparam logic [IDX_W-1:0] IDX_NONE = '1;

  typedef enum logic [1:0] {
    SPC_SRC = 2'd0,
    SPC_NMI = 2'd1,
    SPC_ACT = 2'd2,
    SPC_MAP = 2'd3
  } space_e;
endpackage

// File: rtl/irq_src_cfg.sv
module irq_src_cfg
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int CH_W    = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en_i,
  input  logic [IDX_W-1:0]              wr_idx_i,
  input  logic [CH_W:0]                 wr_data_i,
  output logic [NUM_SRC-1:0]            en_o,
  output logic [NUM_SRC-1:0][CH_W-1:0]  ch_o
);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic            hit;
    logic            en_d, en_q;
    logic [CH_W-1:0] ch_d, ch_q;

    assign hit = wr_en_i && (wr_idx_i == IDX_W'(s));

    always_comb begin
      en_d = wr_data_i[CH_W];
      ch_d = wr_data_i[CH_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q <= 1'b0;
        ch_q <= '0;
      end else if (hit) begin
        en_q <= en_d;
        ch_q <= ch_d;
      end
    end

    assign en_o[s] = en_q;
    assign ch_o[s] = ch_q;

    AST_CFG_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_idx_i == IDX_W'(s)) |=> (en_o[s] == $past(wr_data_i[CH_W]) && ch_o[s] == $past(wr_data_i[CH_W-1:0]))); // R2
  end

endmodule

// File: rtl/irq_nmi_sel.sv
module irq_nmi_sel
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_NMI = 4,
  localparam int SEL_W  = (NUM_NMI > 1) ? $clog2(NUM_NMI) : 1,
  localparam int EXT_W  = 1 << IDX_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en_i,
  input  logic [SEL_W-1:0]               wr_sel_i,
  input  logic [IDX_W-1:0]               wr_data_i,
  input  logic [NUM_SRC-1:0]             src_i,
  output logic [NUM_NMI-1:0][IDX_W-1:0]  sel_o,
  output logic                           nmi_hit_o
);

  logic [EXT_W-1:0] src_ext;
  logic             any_sel;

  assign src_ext = {{(EXT_W-NUM_SRC){1'b0}}, src_i};

  for (genvar k = 0; k < NUM_NMI; k++) begin : g_sel
    logic             hit;
    logic [IDX_W-1:0] sel_d, sel_q;

    assign hit = wr_en_i && (wr_sel_i == SEL_W'(k));

    always_comb begin
      sel_d = wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q <= IDX_NONE;
      end else if (hit) begin
        sel_q <= sel_d;
      end
    end

    assign sel_o[k] = sel_q;
  end

  always_comb begin
    nmi_hit_o = 1'b0;
    any_sel   = 1'b0;
    for (int k = 0; k < NUM_NMI; k++) begin
      if (sel_o[k] != IDX_NONE) begin
        any_sel = 1'b1;
        if (src_ext[sel_o[k]]) nmi_hit_o = 1'b1;
      end
    end
  end

  AST_NMI_NEEDS_SELECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_hit_o |-> any_sel); // R7
  AST_NMI_SEL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (sel_o[$past(wr_sel_i)] == $past(wr_data_i))); // R7

endmodule

// File: rtl/irq_ffs.sv
module irq_ffs
  import irq_router_pkg::*;
#(
  parameter int N   = 64,
  localparam int LV = (N > 1) ? $clog2(N) : 1,
  localparam int P  = 1 << LV
) (
  input  logic [N-1:0]     vec_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);

  logic [P-1:0]     v  [LV+1];
  logic [IDX_W-1:0] id [LV+1][P];
  logic [P-1:0]     vec_ext;
  logic [P-1:0]     below;

  assign vec_ext = P'(vec_i);

  // Pairwise tree: at each level the left (lower) child wins when it has a hit.
  always_comb begin
    for (int l = 0; l <= LV; l++) begin
      v[l] = '0;
      for (int n = 0; n < P; n++) id[l][n] = '0;
    end
    for (int n = 0; n < P; n++) begin
      v[0][n]  = vec_ext[n];
      id[0][n] = IDX_W'(n);
    end
    for (int l = 1; l <= LV; l++) begin
      for (int n = 0; n < (P >> l); n++) begin
        v[l][n]  = v[l-1][2*n] | v[l-1][2*n+1];
        id[l][n] = v[l-1][2*n] ? id[l-1][2*n] : id[l-1][2*n+1];
      end
    end
  end

  assign found_o = v[LV][0];
  assign idx_o   = found_o ? id[LV][0] : IDX_NONE;

  assign below = (P'(1) << idx_o[LV-1:0]) - P'(1);

  always_comb begin
    if (found_o) begin
      AST_FFS_LOWEST: assert (vec_ext[idx_o[LV-1:0]] && ((vec_ext & below) == '0)); // R5
    end
  end

endmodule

// File: rtl/irq_src_router.sv
module irq_src_router
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_CH  = 8,
  parameter int NUM_NMI = 4,
  parameter int DS_CH   = 2,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int SEL_W  = (NUM_NMI > 1) ? $clog2(NUM_NMI) : 1,
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_SRC-1:0]      src_i,
  input  logic                    deep_sleep_i,
  input  logic                    cfg_we_i,
  input  logic [ADDR_W-1:0]       cfg_addr_i,
  input  logic [IDX_W-1:0]        cfg_wdata_i,
  output logic [IDX_W-1:0]        cfg_rdata_o,
  output logic [NUM_CH-1:0]       irq_o,
  output logic [NUM_CH*IDX_W-1:0] act_idx_o,
  output logic                    nmi_o
);

  space_e                          space;
  logic [IDX_W-1:0]                idx;
  logic                            src_we, nmi_we;
  logic [NUM_SRC-1:0]              en;
  logic [NUM_SRC-1:0][CH_W-1:0]    ch;
  logic [NUM_NMI-1:0][IDX_W-1:0]   sel;
  logic                            nmi_hit;
  logic [NUM_SRC-1:0]              hit [NUM_CH];
  logic [NUM_CH-1:0]               found;
  logic [IDX_W-1:0]                win [NUM_CH];

  logic [NUM_CH-1:0]               irq_d, irq_q;
  logic [IDX_W-1:0]                act_d [NUM_CH];
  logic [IDX_W-1:0]                act_q [NUM_CH];
  logic                            nmi_d, nmi_q;

  assign space  = space_e'(cfg_addr_i[ADDR_W-1:IDX_W]);
  assign idx    = cfg_addr_i[IDX_W-1:0];
  assign src_we = cfg_we_i && (space == SPC_SRC) && (idx < IDX_W'(NUM_SRC));
  assign nmi_we = cfg_we_i && (space == SPC_NMI) && (idx < IDX_W'(NUM_NMI));

  irq_src_cfg #(
    .NUM_SRC (NUM_SRC),
    .CH_W    (CH_W)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (src_we),
    .wr_idx_i  (idx),
    .wr_data_i (cfg_wdata_i[CH_W:0]),
    .en_o      (en),
    .ch_o      (ch)
  );

  irq_nmi_sel #(
    .NUM_SRC (NUM_SRC),
    .NUM_NMI (NUM_NMI)
  ) u_nmi (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (nmi_we),
    .wr_sel_i  (idx[SEL_W-1:0]),
    .wr_data_i (cfg_wdata_i),
    .src_i     (src_i),
    .sel_o     (sel),
    .nmi_hit_o (nmi_hit)
  );

  // Per-channel membership of every active, enabled source.
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        hit[c][s] = src_i[s] & en[s] & (ch[s] == CH_W'(c));
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    irq_ffs #(
      .N (NUM_SRC)
    ) u_ffs (
      .vec_i   (hit[c]),
      .found_o (found[c]),
      .idx_o   (win[c])
    );

    if (c < DS_CH) begin : g_wake
      assign irq_d[c] = found[c];
    end else begin : g_gated
      assign irq_d[c] = found[c] & ~deep_sleep_i;
      AST_SLEEP_MASKS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        deep_sleep_i |=> !irq_o[c]); // R8
    end

    assign act_d[c] = win[c];
    assign act_idx_o[c*IDX_W +: IDX_W] = act_q[c];

    AST_REQ_HAS_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[c] |-> (act_q[c] != IDX_NONE)); // R3
    AST_IDLE_IS_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q[c] == IDX_NONE) |-> !irq_o[c]); // R6
    AST_WINNER_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q[c] != IDX_NONE) |-> (act_q[c] < IDX_W'(NUM_SRC))); // R5
  end

  assign nmi_d = nmi_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
      nmi_q <= 1'b0;
      for (int c = 0; c < NUM_CH; c++) act_q[c] <= IDX_NONE;
    end else begin
      irq_q <= irq_d;
      nmi_q <= nmi_d;
      for (int c = 0; c < NUM_CH; c++) act_q[c] <= act_d[c];
    end
  end

  assign irq_o = irq_q;
  assign nmi_o = nmi_q;

  // Register read decode.
  always_comb begin
    cfg_rdata_o = '0;
    case (space)
      SPC_SRC: begin
        for (int s = 0; s < NUM_SRC; s++) begin
          if (idx == IDX_W'(s)) cfg_rdata_o = IDX_W'({en[s], ch[s]});
        end
      end
      SPC_NMI: begin
        for (int k = 0; k < NUM_NMI; k++) begin
          if (idx == IDX_W'(k)) cfg_rdata_o = sel[k];
        end
      end
      SPC_ACT: begin
        cfg_rdata_o = IDX_NONE;
        for (int c = 0; c < NUM_CH; c++) begin
          if (idx == IDX_W'(c)) cfg_rdata_o = act_q[c];
        end
      end
      default: begin
        cfg_rdata_o = IDX_NONE;
        for (int s = 0; s < NUM_SRC; s++) begin
          if (idx == IDX_W'(s) && en[s]) cfg_rdata_o = IDX_W'(ch[s]);
        end
      end
    endcase
  end

  AST_NMI_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (!nmi_hit) |=> !nmi_o); // R7

endmodule

// File: tb/tb_irq_src_router.sv
`timescale 1ns/1ps
module tb_irq_src_router;
  localparam int NS = 64;
  localparam int NC = 8;
  localparam int NN = 4;
  localparam int DSC = 2;
  localparam logic [9:0] NONE = 10'h3FF;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NS-1:0]   src;
  logic            dsl;
  logic            cfg_we;
  logic [11:0]     cfg_addr;
  logic [9:0]      cfg_wdata;
  logic [9:0]      cfg_rdata;
  logic [NC-1:0]   irq;
  logic [NC*10-1:0] act;
  logic            nmi;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [NC-1:0]    irq;
    logic [NC*10-1:0] act;
    logic             nmi;
    string            tag;
  } exp_t;
  exp_t q[$];

  logic       m_en  [NS];
  logic [2:0] m_ch  [NS];
  logic [9:0] m_sel [NN];

  always #2 clk = ~clk;

  irq_src_router #(.NUM_SRC(NS), .NUM_CH(NC), .NUM_NMI(NN), .DS_CH(DSC)) dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .deep_sleep_i(dsl),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .irq_o(irq), .act_idx_o(act), .nmi_o(nmi)
  );

  function automatic logic [9:0] f_act(input logic [NS-1:0] s, input int c);
    for (int k = 0; k < NS; k++)
      if (s[k] && m_en[k] && m_ch[k] == 3'(c)) return 10'(k);
    return NONE;
  endfunction

  function automatic logic f_nmi(input logic [NS-1:0] s);
    for (int k = 0; k < NN; k++)
      if (m_sel[k] != NONE && m_sel[k] < 10'(NS) && s[m_sel[k]]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [11:0] ad(input int sp, input int i);
    return {2'(sp), 10'(i)};
  endfunction

  task automatic step(input logic [NS-1:0] s, input logic ds, input logic we,
                      input logic [11:0] a, input logic [9:0] d, input string tag);
    exp_t e;
    @(negedge clk);
    src = s; dsl = ds; cfg_we = we; cfg_addr = a; cfg_wdata = d;
    for (int c = 0; c < NC; c++) begin
      e.act[c*10 +: 10] = f_act(s, c);
      e.irq[c] = (e.act[c*10 +: 10] != NONE) && (!ds || c < DSC);
    end
    e.nmi = f_nmi(s);
    e.tag = tag;
    q.push_back(e);
    if (we) begin
      if (a[11:10] == 2'd0 && a[9:0] < 10'(NS)) begin
        m_en[a[9:0]] = d[3];
        m_ch[a[9:0]] = d[2:0];
      end else if (a[11:10] == 2'd1 && a[9:0] < 10'(NN)) begin
        m_sel[a[9:0]] = d;
      end
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [9:0] d, input string tag);
    step(src, dsl, 1'b1, a, d, tag);
  endtask

  task automatic rd(input logic [11:0] a, input logic [9:0] exp, input string tag);
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr = a;
    #1;
    checks++;
    if (cfg_rdata !== exp) begin
      errors++;
      $display("FAIL %s read addr=%h got %h exp %h", tag, a, cfg_rdata, exp);
    end
  endtask

  task automatic drain();
    @(negedge clk);
    cfg_we = 1'b0;
    while (q.size() != 0) @(negedge clk);
  endtask

  // Monitor: pops one expected item per cycle just after the edge that produced it.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks += 3;
        if (irq !== e.irq) begin
          errors++;
          $display("FAIL %s irq got %b exp %b", e.tag, irq, e.irq);
        end
        if (act !== e.act) begin
          errors++;
          $display("FAIL %s act got %h exp %h", e.tag, act, e.act);
        end
        if (nmi !== e.nmi) begin
          errors++;
          $display("FAIL %s nmi got %b exp %b", e.tag, nmi, e.nmi);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    logic [NS-1:0] one;
    rst_n = 1'b0; src = '0; dsl = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    for (int k = 0; k < NS; k++) begin m_en[k] = 1'b0; m_ch[k] = '0; end
    for (int k = 0; k < NN; k++) m_sel[k] = NONE;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    checks++;
    if (irq !== '0 || nmi !== 1'b0) begin
      errors++; $display("FAIL R1 irq/nmi got %b/%b exp 0/0", irq, nmi);
    end
    checks++;
    if (act !== {NC{NONE}}) begin
      errors++; $display("FAIL R1 act got %h exp all 3ff", act);
    end
    rd(ad(0, 5), 10'h000, "R1 src cfg");
    rd(ad(1, 2), NONE, "R1 nmi sel");
    rd(ad(2, 6), NONE, "R1 winner");

    // R2 configuration
    wr(ad(0, 29), 10'h00B, "R2 cfg");
    wr(ad(0, 46), 10'h00B, "R2 cfg");
    wr(ad(0, 5),  10'h008, "R2 cfg");
    wr(ad(0, 60), 10'h00F, "R2 cfg");
    wr(ad(0, 10), 10'h002, "R2 cfg");
    drain();
    rd(ad(0, 29), 10'h00B, "R2 readback");
    rd(ad(0, 10), 10'h002, "R2 readback");
    rd(ad(3, 29), 10'h003, "R9 map enabled");
    rd(ad(3, 10), NONE, "R9 map disabled");

    // R3/R5/R6 priority and OR
    one = '0; one[46] = 1'b1;
    step(one, 1'b0, 1'b0, '0, '0, "R3 single source");
    one[29] = 1'b1;
    step(one, 1'b0, 1'b0, '0, '0, "R5 lower index wins");
    drain();
    rd(ad(2, 3), 10'd29, "R5 winner read");
    one = '0; one[10] = 1'b1;
    step(one, 1'b0, 1'b0, '0, '0, "R4 disabled source");
    drain();
    rd(ad(2, 2), NONE, "R6 none pending");
    rd(ad(2, 3), NONE, "R6 none pending");
    one = '0; one[5] = 1'b1; one[60] = 1'b1;
    step(one, 1'b0, 1'b0, '0, '0, "R3 two channels");
    // R8 deep sleep
    step(one, 1'b1, 1'b0, '0, '0, "R8 sleep masks upper");
    step(one, 1'b0, 1'b0, '0, '0, "R8 wake restores");

    // R7 NMI
    wr(ad(1, 0), 10'd10, "R7 sel");
    wr(ad(1, 2), 10'd46, "R7 sel");
    one = '0; one[10] = 1'b1;
    step(one, 1'b0, 1'b0, '0, '0, "R7 raw disabled source");
    drain();
    rd(ad(1, 2), 10'd46, "R7 sel readback");
    wr(ad(1, 0), NONE, "R7 disconnect");
    step(one, 1'b0, 1'b0, '0, '0, "R7 disconnected");
    one = '0; one[46] = 1'b1;
    step(one, 1'b0, 1'b0, '0, '0, "R7 second selector");

    // R10 out-of-range index
    wr(ad(0, 100), 10'h00D, "R10 write ignored");
    wr(ad(0, NS), 10'h00D, "R10 write ignored");
    drain();
    rd(ad(0, 100), 10'h000, "R10 read zero");
    rd(ad(3, NS), NONE, "R10 map none");

    // R3 reassignment then dense pseudo-random sweep
    wr(ad(0, 46), 10'h009, "R3 reassign");
    step(one, 1'b0, 1'b0, '0, '0, "R3 new channel");
    for (int k = 0; k < NS; k += 3) wr(ad(0, k), 10'(8 | (k % 8)), "R2 dense cfg");
    wr(ad(0, 7), 10'h004, "R4 disable");
    lf = 32'h1D872B41;
    for (int i = 0; i < 40; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      one = {lf & {lf[15:0], lf[31:16]}, lf ^ 32'h5A3C96E1} & {NS{lf[3]}} | {lf, ~lf} & {NS{~lf[3]}};
      step(one, i[2], 1'b0, '0, '0, "R3/R5/R8 sweep");
    end
    step('0, 1'b0, 1'b0, '0, '0, "R6 all idle");
    drain();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule